// File: doc/BRIEF.md
# Sleep-Handshake Clock Gating Controller

This block produces one clock-enable level per clock domain, for up to 32 domains. Software programs it through a small register port. There are three gating masks, an acknowledge-monitor mask, a delay value and a global control register. Every mask uses the same layout: bit i belongs to domain i. Three things can turn a domain's enable off. An immediate mask does it unconditionally. A debug mask does it once a debug event has been latched. A sleep mask does it only while a sleep handshake is acknowledged.

A power management controller raises a sleep request and waits for the acknowledge. The acknowledge can come from one of two sources, chosen by a global bit. In monitor mode it rises once every domain picked by the acknowledge-monitor mask reports its clock inactive. In delay mode it rises once a programmable count of reference clock edges has run out. When the request falls, the acknowledge falls, the sleep gating is released and the delay counter returns to idle. The outputs are enable levels only. The glitch-free gate cells and any crossing between clock domains sit outside this block.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: After reset all writable registers read zero and every `clk_en_o` bit is 1. The register map is: 0 control (bit 1 = delay-mode select), 1 clock-active status, 2 immediate-off mask, 3 debug-stop mask, 4 ack-monitor mask, 5 sleep-off mask, 6 delay value (32 bits), 7 debug status (bit 0 = debug-stop latched). A write to 2..6 reads back the written value, trimmed to the field width.
- R2: Address 1 is read-only and returns `clk_active_i`. A write to it changes no register and no enable.
- R3: A 1 in the immediate-off mask clears that domain's enable from the cycle after the write, whatever the sleep or debug state.
- R4: With control bit 1 at 0, the acknowledge rises on the second clock edge after the request is first sampled, provided no domain picked by the ack-monitor mask is active. Otherwise it rises on the edge after the last such domain goes inactive. An empty mask therefore acknowledges after two edges.
- R5: With control bit 1 at 1, the ack-monitor mask and the activity inputs are ignored. With delay value D, the acknowledge rises on edge D+2 after the request is first sampled, so D=0 acknowledges after two edges.
- R6: When the request falls, the acknowledge falls on the next edge and the sleep-off gating is released. A new request restarts the full wait, including a fresh load of the delay.
- R7: A 1 in the sleep-off mask clears that domain's enable only while the acknowledge is high.
- R8: A debug event sampled at a clock edge latches the debug-stop state. From then on the domains in the debug-stop mask are gated, and status bit 0 reads 1.
- R9: The latched debug-stop state holds until a 1 is written to bit 0 of address 7. Writing 0 there leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| clk_active_i | input | NUM_DOM | Per-domain clock-running status |
| dbg_evt_i | input | 1 | Debug event or trigger |
| slp_req_i | input | 1 | Sleep request from the power management controller |
| slp_ack_o | output | 1 | Sleep acknowledge |
| clk_en_o | output | NUM_DOM | Per-domain clock enable |

## Verification
The bench builds the block with NUM_DOM = 8 and DLY_W = 32. With 8 domains, the bench can use masks that pick some domains and leave others out, so it can show that unmonitored activity does not hold back the acknowledge and that gating touches only the chosen bits. With the full 32-bit delay field, the bench checks the write-and-readback path at full width. Small delay values (0 and 5) then bring both edge timings of the delay mode within a short run.

// File: rtl/sccg_pkg.sv
package sccg_pkg;
   localparam int REG_DW = 32;
   localparam int ADR_W  = 3;

   localparam logic [ADR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADR_W-1:0] A_ACTIVE = 3'd1;
   localparam logic [ADR_W-1:0] A_FORCE  = 3'd2;
   localparam logic [ADR_W-1:0] A_DBGM   = 3'd3;
   localparam logic [ADR_W-1:0] A_ACKM   = 3'd4;
   localparam logic [ADR_W-1:0] A_SLPM   = 3'd5;
   localparam logic [ADR_W-1:0] A_DELAY  = 3'd6;
   localparam logic [ADR_W-1:0] A_DBGST  = 3'd7;

   localparam int CTRL_DLY_BIT = 1;

   typedef enum logic [1:0] {
      SL_IDLE = 2'd0,
      SL_WAIT = 2'd1,
      SL_ACK  = 2'd2
   } sl_state_t;
endpackage

// File: rtl/sccg_regs.sv
module sccg_regs
   import sccg_pkg::*;
#(
   parameter int NUM_DOM = 8,
   parameter int DLY_W   = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               reg_wr_i,
   input  logic [ADR_W-1:0]   reg_addr_i,
   input  logic [REG_DW-1:0]  reg_wdata_i,
   output logic [REG_DW-1:0]  reg_rdata_o,
   input  logic [NUM_DOM-1:0] clk_active_i,
   input  logic               dbg_evt_i,
   output logic [NUM_DOM-1:0] force_off_o,
   output logic [NUM_DOM-1:0] dbg_mask_o,
   output logic [NUM_DOM-1:0] ack_mask_o,
   output logic [NUM_DOM-1:0] slp_off_o,
   output logic [DLY_W-1:0]   dly_val_o,
   output logic               dly_en_o,
   output logic               dbg_stop_o
);
   logic dbg_clr;

   assign dbg_clr = reg_wr_i && (reg_addr_i == A_DBGST) && reg_wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         force_off_o <= '0;
         dbg_mask_o  <= '0;
         ack_mask_o  <= '0;
         slp_off_o   <= '0;
         dly_val_o   <= '0;
         dly_en_o    <= 1'b0;
      end else if (reg_wr_i) begin
         case (reg_addr_i)
            A_CTRL:  dly_en_o    <= reg_wdata_i[CTRL_DLY_BIT];
            A_FORCE: force_off_o <= reg_wdata_i[NUM_DOM-1:0];
            A_DBGM:  dbg_mask_o  <= reg_wdata_i[NUM_DOM-1:0];
            A_ACKM:  ack_mask_o  <= reg_wdata_i[NUM_DOM-1:0];
            A_SLPM:  slp_off_o   <= reg_wdata_i[NUM_DOM-1:0];
            A_DELAY: dly_val_o   <= reg_wdata_i[DLY_W-1:0];
            default: ;
         endcase
      end
   end

   // debug latch: a new event wins over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dbg_stop_o <= 1'b0;
      else if (dbg_evt_i) dbg_stop_o <= 1'b1;
      else if (dbg_clr)   dbg_stop_o <= 1'b0;
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_CTRL:   reg_rdata_o[CTRL_DLY_BIT] = dly_en_o;
         A_ACTIVE: reg_rdata_o[NUM_DOM-1:0] = clk_active_i;
         A_FORCE:  reg_rdata_o[NUM_DOM-1:0] = force_off_o;
         A_DBGM:   reg_rdata_o[NUM_DOM-1:0] = dbg_mask_o;
         A_ACKM:   reg_rdata_o[NUM_DOM-1:0] = ack_mask_o;
         A_SLPM:   reg_rdata_o[NUM_DOM-1:0] = slp_off_o;
         A_DELAY:  reg_rdata_o[DLY_W-1:0]   = dly_val_o;
         A_DBGST:  reg_rdata_o[0]           = dbg_stop_o;
         default:  reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/sccg_sleep_seq.sv
module sccg_sleep_seq
   import sccg_pkg::*;
#(
   parameter int NUM_DOM = 8,
   parameter int DLY_W   = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               slp_req_i,
   input  logic               dly_en_i,
   input  logic [DLY_W-1:0]   dly_val_i,
   input  logic [NUM_DOM-1:0] ack_mask_i,
   input  logic [NUM_DOM-1:0] clk_active_i,
   output logic               slp_ack_o
);
   sl_state_t        st_q, st_d;
   logic [DLY_W-1:0] cnt_q, cnt_d;
   logic             mon_idle;
   logic             done;

   assign mon_idle = ~|(clk_active_i & ack_mask_i);
   assign done     = dly_en_i ? (cnt_q == '0) : mon_idle;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (!slp_req_i) begin
         st_d  = SL_IDLE;
         cnt_d = '0;
      end else begin
         case (st_q)
            SL_IDLE: begin
               st_d  = SL_WAIT;
               cnt_d = dly_val_i;
            end
            SL_WAIT: begin
               if (done) st_d = SL_ACK;
               else if (dly_en_i) cnt_d = cnt_q - 1'b1;
            end
            SL_ACK:  st_d = SL_ACK;
            default: st_d = SL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= SL_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign slp_ack_o = (st_q == SL_ACK);
endmodule

// File: rtl/sccg_gate.sv
module sccg_gate #(
   parameter int NUM_DOM = 8
) (
   input  logic [NUM_DOM-1:0] force_off_i,
   input  logic [NUM_DOM-1:0] dbg_mask_i,
   input  logic [NUM_DOM-1:0] slp_off_i,
   input  logic               dbg_stop_i,
   input  logic               slp_ack_i,
   output logic [NUM_DOM-1:0] clk_en_o
);
   for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
      logic off_dbg, off_slp;
      assign off_dbg     = dbg_stop_i & dbg_mask_i[i];
      assign off_slp     = slp_ack_i & slp_off_i[i];
      assign clk_en_o[i] = ~(force_off_i[i] | off_dbg | off_slp);
   end
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
   import sccg_pkg::*;
#(
   parameter int NUM_DOM = 8,
   parameter int DLY_W   = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               reg_wr_i,
   input  logic [2:0]         reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   input  logic [NUM_DOM-1:0] clk_active_i,
   input  logic               dbg_evt_i,
   input  logic               slp_req_i,
   output logic               slp_ack_o,
   output logic [NUM_DOM-1:0] clk_en_o
);
   if (NUM_DOM < 1 || NUM_DOM > REG_DW) begin : g_bad_dom
      $error("sleep_clkgate_ctrl: NUM_DOM must be 1..32");
   end
   if (DLY_W < 1 || DLY_W > REG_DW) begin : g_bad_dly
      $error("sleep_clkgate_ctrl: DLY_W must be 1..32");
   end

   logic [NUM_DOM-1:0] force_off, dbg_mask, ack_mask, slp_off;
   logic [DLY_W-1:0]   dly_val;
   logic               dly_en, dbg_stop;

   sccg_regs #(.NUM_DOM(NUM_DOM), .DLY_W(DLY_W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .reg_wr_i     (reg_wr_i),
      .reg_addr_i   (reg_addr_i),
      .reg_wdata_i  (reg_wdata_i),
      .reg_rdata_o  (reg_rdata_o),
      .clk_active_i (clk_active_i),
      .dbg_evt_i    (dbg_evt_i),
      .force_off_o  (force_off),
      .dbg_mask_o   (dbg_mask),
      .ack_mask_o   (ack_mask),
      .slp_off_o    (slp_off),
      .dly_val_o    (dly_val),
      .dly_en_o     (dly_en),
      .dbg_stop_o   (dbg_stop)
   );

   sccg_sleep_seq #(.NUM_DOM(NUM_DOM), .DLY_W(DLY_W)) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .slp_req_i    (slp_req_i),
      .dly_en_i     (dly_en),
      .dly_val_i    (dly_val),
      .ack_mask_i   (ack_mask),
      .clk_active_i (clk_active_i),
      .slp_ack_o    (slp_ack_o)
   );

   sccg_gate #(.NUM_DOM(NUM_DOM)) u_gate (
      .force_off_i (force_off),
      .dbg_mask_i  (dbg_mask),
      .slp_off_i   (slp_off),
      .dbg_stop_i  (dbg_stop),
      .slp_ack_i   (slp_ack_o),
      .clk_en_o    (clk_en_o)
   );
endmodule

// File: rtl/sccg_chk.sv
module sccg_chk #(
   parameter int NUM_DOM = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               reg_wr_i,
   input logic [2:0]         reg_addr_i,
   input logic               wdata0_i,
   input logic               slp_req_i,
   input logic               slp_ack_i,
   input logic [NUM_DOM-1:0] clk_active_i,
   input logic [NUM_DOM-1:0] clk_en_i,
   input logic [NUM_DOM-1:0] force_off_i,
   input logic [NUM_DOM-1:0] ack_mask_i,
   input logic [NUM_DOM-1:0] slp_off_i,
   input logic [NUM_DOM-1:0] dbg_mask_i,
   input logic               dly_en_i,
   input logic               dbg_stop_i
);
   AST_FORCE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_i & force_off_i) == '0); // R3

   AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slp_req_i |=> !slp_ack_i); // R6

   AST_MON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(slp_ack_i) && !$past(dly_en_i)) |-> ($past(clk_active_i & ack_mask_i) == '0)); // R4

   AST_SLPOFF_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slp_ack_i |-> ((~clk_en_i) & slp_off_i & ~force_off_i
                      & ~(dbg_mask_i & {NUM_DOM{dbg_stop_i}})) == '0); // R7

   AST_DBG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_stop_i && !(reg_wr_i && reg_addr_i == 3'd7 && wdata0_i)) |=> dbg_stop_i); // R9
endmodule

bind sleep_clkgate_ctrl sccg_chk #(.NUM_DOM(NUM_DOM)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .reg_wr_i     (reg_wr_i),
   .reg_addr_i   (reg_addr_i),
   .wdata0_i     (reg_wdata_i[0]),
   .slp_req_i    (slp_req_i),
   .slp_ack_i    (slp_ack_o),
   .clk_active_i (clk_active_i),
   .clk_en_i     (clk_en_o),
   .force_off_i  (force_off),
   .ack_mask_i   (ack_mask),
   .slp_off_i    (slp_off),
   .dbg_mask_i   (dbg_mask),
   .dly_en_i     (dly_en),
   .dbg_stop_i   (dbg_stop)
);

// File: tb/sleep_clkgate_ctrl_tb.sv
module sleep_clkgate_ctrl_tb;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr = 1'b0;
   logic [2:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [N-1:0] active = '0;
   logic         dbg = 1'b0;
   logic         req = 1'b0;
   logic         ack;
   logic [N-1:0] en;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   sleep_clkgate_ctrl #(.NUM_DOM(N), .DLY_W(32)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_active_i(active),
      .dbg_evt_i(dbg), .slp_req_i(req), .slp_ack_o(ack), .clk_en_o(en)
   );

   task automatic chk(input string req_tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         if (a != 1) begin
            rd_reg(3'(a), d);
            chk("R1", "reset register", d, 32'h0);
         end
      end
      chk("R1", "reset enables", 32'(en), 32'h0000_00FF);
      chk("R1", "reset ack", 32'(ack), 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr_reg(3'd2, 32'hFFFF_FF00); rd_reg(3'd2, d); chk("R1", "force rb", d, 32'h0);
      wr_reg(3'd3, 32'h0000_00A5); rd_reg(3'd3, d); chk("R1", "dbgm rb", d, 32'hA5);
      wr_reg(3'd4, 32'h0000_015A); rd_reg(3'd4, d); chk("R1", "ackm rb", d, 32'h5A);
      wr_reg(3'd5, 32'h0000_003C); rd_reg(3'd5, d); chk("R1", "slpm rb", d, 32'h3C);
      wr_reg(3'd6, 32'hDEAD_BEEF); rd_reg(3'd6, d); chk("R1", "delay rb", d, 32'hDEAD_BEEF);
      wr_reg(3'd0, 32'hFFFF_FFFF); rd_reg(3'd0, d); chk("R1", "ctrl rb", d, 32'h2);
      for (int a = 0; a < 7; a++) if (a != 1) wr_reg(3'(a), 32'h0);
   endtask

   task automatic t_active_ro();
      logic [31:0] d;
      active = 8'h5A;
      wr_reg(3'd1, 32'hFFFF_FFFF);
      rd_reg(3'd1, d);
      chk("R2", "active readback", d, 32'h5A);
      chk("R2", "enables after ro write", 32'(en), 32'hFF);
      rd_reg(3'd2, d);
      chk("R2", "force untouched", d, 32'h0);
      active = 8'h00;
      #1;
      rd_reg(3'd1, d);
      chk("R2", "active follows input", d, 32'h0);
   endtask

   task automatic t_force();
      wr_reg(3'd2, 32'h81);
      chk("R3", "force gating", 32'(en), 32'h7E);
      wr_reg(3'd2, 32'h0);
      chk("R3", "force release", 32'(en), 32'hFF);
   endtask

   task automatic t_empty_mask();
      wr_reg(3'd5, 32'h0F);
      req = 1'b1;
      cyc(1);
      chk("R4", "empty mask ack edge1", 32'(ack), 32'h0);
      chk("R7", "no sleep gating before ack", 32'(en), 32'hFF);
      cyc(1);
      chk("R4", "empty mask ack edge2", 32'(ack), 32'h1);
      chk("R7", "sleep gating with ack", 32'(en), 32'hF0);
      req = 1'b0;
      cyc(1);
      chk("R6", "ack drop", 32'(ack), 32'h0);
      chk("R6", "sleep gating released", 32'(en), 32'hFF);
   endtask

   task automatic t_mon();
      wr_reg(3'd4, 32'h03);
      active = 8'h03;
      req = 1'b1;
      cyc(4);
      chk("R4", "busy monitored holds ack", 32'(ack), 32'h0);
      active = 8'h02;
      cyc(2);
      chk("R4", "one still busy", 32'(ack), 32'h0);
      active = 8'hFC;
      cyc(1);
      chk("R4", "ack after monitored idle", 32'(ack), 32'h1);
      chk("R7", "sleep mask gated", 32'(en), 32'hF0);
      req = 1'b0;
      cyc(1);
      chk("R6", "monitor ack drop", 32'(ack), 32'h0);
      active = 8'h00;
   endtask

   task automatic t_delay();
      wr_reg(3'd0, 32'h2);
      wr_reg(3'd4, 32'hFF);
      wr_reg(3'd6, 32'd5);
      active = 8'hFF;
      req = 1'b1;
      cyc(6);
      chk("R5", "delay ack edge D+1", 32'(ack), 32'h0);
      cyc(1);
      chk("R5", "delay ack edge D+2", 32'(ack), 32'h1);
      req = 1'b0;
      cyc(1);
      chk("R6", "delay ack drop", 32'(ack), 32'h0);
      req = 1'b1;
      cyc(6);
      chk("R6", "restart reloads delay", 32'(ack), 32'h0);
      cyc(1);
      chk("R6", "restart acks at D+2", 32'(ack), 32'h1);
      req = 1'b0;
      cyc(1);
      wr_reg(3'd6, 32'd0);
      req = 1'b1;
      cyc(1);
      chk("R5", "zero delay edge1", 32'(ack), 32'h0);
      cyc(1);
      chk("R5", "zero delay edge2", 32'(ack), 32'h1);
      req = 1'b0;
      cyc(1);
      active = 8'h00;
      wr_reg(3'd0, 32'h0);
      wr_reg(3'd4, 32'h0);
   endtask

   task automatic t_force_over_release();
      wr_reg(3'd5, 32'hF0);
      req = 1'b1;
      cyc(2);
      chk("R7", "sleep gating upper", 32'(en), 32'h0F);
      wr_reg(3'd2, 32'h80);
      req = 1'b0;
      cyc(1);
      chk("R3", "force holds after release", 32'(en), 32'h7F);
      wr_reg(3'd2, 32'h0);
      wr_reg(3'd5, 32'h0);
      chk("R3", "all released", 32'(en), 32'hFF);
   endtask

   task automatic t_dbg();
      logic [31:0] d;
      wr_reg(3'd3, 32'h0C);
      chk("R8", "no gating before event", 32'(en), 32'hFF);
      dbg = 1'b1;
      cyc(1);
      dbg = 1'b0;
      chk("R8", "debug gating", 32'(en), 32'hF3);
      cyc(5);
      rd_reg(3'd7, d);
      chk("R8", "debug status", d, 32'h1);
      wr_reg(3'd7, 32'h0);
      chk("R9", "write zero keeps latch", 32'(en), 32'hF3);
      wr_reg(3'd7, 32'h1);
      chk("R9", "w1c releases", 32'(en), 32'hFF);
      rd_reg(3'd7, d);
      chk("R9", "status cleared", d, 32'h0);
      wr_reg(3'd3, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_active_ro();
      t_force();
      t_empty_mask();
      t_mon();
      t_delay();
      t_force_over_release();
      t_dbg();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule